// File: doc/BRIEF.md
# Low-Power Pad State Retention Lock

This block sits between a GPIO port's configuration registers and its pads. In normal operation the pads follow the live registers: output enable, output value, pull enable, pull direction and drive strength. When the power controller signals entry into a deep low-power mode, the block copies the present pad controls into a retention latch, sets a lock bit, and from then on drives the pads from that copy. The wake-up reset returns the configuration registers to their defaults, but the pads do not change. Software reloads the registers and then writes 0 to the lock bit, which hands the pads back to the live register values.

The lock bit, the retained pad copy, the pin interrupt flags and the sleep state all live in a retention domain with its own reset (`por_n`). The wake-up reset (`rst_n`) does not touch them. Each pin has an interrupt flag that is set by a selected edge. While the lock is held, software may set flags but cannot clear them. An enabled edge during sleep raises a one-cycle wake request.

Register write map (`wr_addr`): 0 direction, 1 output value, 2 pull enable, 3 drive strength, 4 edge select, 5 interrupt enable, 6 interrupt flags, 7 lock (bit 0).

Top module: `pad_hold_lock`

## Requirements
- R1: While `por_n` is low, `lock_active`, `irq_flags` and `wake_req` are 0. With the registers at their default of 0, every pad output is 0.
- R2: While unlocked, the following hold one cycle after a register write: `pad_oe` equals direction, `pad_do` equals output value, `pad_pull_up` equals output value, `pad_drive` equals drive strength, and `pad_pull_en` equals pull enable AND NOT direction.
- R3: A cycle with `sleep_enter` high sets `lock_active` at that clock edge. The pad outputs keep the values the live registers had at that edge.
- R4: While locked, writes to the direction, output, pull-enable and drive registers do not change any pad output.
- R5: While locked, `rst_n` low clears the configuration registers, but pads, `lock_active` and `irq_flags` keep their values. Only `por_n` resets them.
- R6: Writing a value with bit 0 = 0 to address 7 clears the lock, and the pads then show the live register values. Writing bit 0 = 1 has no effect. If `sleep_enter` is high in the same cycle as a clear write, the lock stays set.
- R7: A pin's flag is set at the first clock edge that sees a low-to-high change when its edge-select bit is 0, or a high-to-low change when the bit is 1. The opposite edge does not set the flag.
- R8: A write to address 6 replaces the flags while unlocked. While locked, the write can only set flag bits, never clear them.
- R9: After `sleep_enter` and until a wake event, a selected edge on a pin whose interrupt enable is 1 sets `wake_req` high for exactly one cycle and ends the sleep state. Edges on pins that are not enabled set flags but raise no wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low retention-domain reset |
| rst_n | input | 1 | Active-low wake-up reset for configuration registers |
| sleep_enter | input | 1 | Low-power entry event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | N | Register write data |
| pad_in | input | N | Pad input levels |
| pad_oe | output | N | Pad output enable |
| pad_do | output | N | Pad output value |
| pad_pull_en | output | N | Pad pull resistor enable |
| pad_pull_up | output | N | Pad pull direction, 1 = up |
| pad_drive | output | N | Pad full drive strength |
| lock_active | output | 1 | Lock bit |
| irq_flags | output | N | Pin interrupt flags |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The bench applies the wake-up reset while the pads are locked. A design that put the retained copy or the lock in the wrong reset domain would drop the pads to 0 at that point. The bench also writes 0 to the flags while locked; a design that missed the clear block would lose the wake cause. It drives an edge on a pin that is not enabled during sleep, which a loose wake decoder would treat as a wake event. Finally, it raises entry and a lock-clear write in the same cycle, which exposes the wrong priority as an unlocked port.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic [2:0] {
    A_DIR  = 3'd0,
    A_OUT  = 3'd1,
    A_PEN  = 3'd2,
    A_DS   = 3'd3,
    A_IES  = 3'd4,
    A_IE   = 3'd5,
    A_FLAG = 3'd6,
    A_LOCK = 3'd7
  } reg_addr_e;

  localparam int unsigned CFG_REGS = 6;
  localparam int unsigned PAD_FIELDS = 5;
  localparam int unsigned F_OE = 0;
  localparam int unsigned F_DO = 1;
  localparam int unsigned F_PEN = 2;
  localparam int unsigned F_PUP = 3;
  localparam int unsigned F_DRV = 4;
endpackage

// File: rtl/hold_cfg_regs.sv
module hold_cfg_regs
  import hold_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [N-1:0]         wr_data,
  output logic [CFG_REGS-1:0][N-1:0] cfg_q
);
  for (genvar g = 0; g < CFG_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == 3'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q[g] <= '0;
      else if (hit) cfg_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/hold_latch.sv
module hold_latch
  import hold_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic                          clk,
  input  logic                          por_n,
  input  logic                          sleep_enter,
  input  logic                          lock_clr,
  input  logic [PAD_FIELDS-1:0][N-1:0]  live,
  output logic [PAD_FIELDS-1:0][N-1:0]  pads,
  output logic                          lock_q
);
  logic [PAD_FIELDS-1:0][N-1:0] held_q;
  logic capture_ev;
  logic release_ev;

  assign capture_ev = sleep_enter && !lock_q;
  assign release_ev = lock_clr && !sleep_enter;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q <= 1'b0;
      held_q <= '0;
    end else begin
      if (capture_ev) held_q <= live;
      if (sleep_enter)     lock_q <= 1'b1;
      else if (release_ev) lock_q <= 1'b0;
    end
  end

  assign pads = lock_q ? held_q : live;

  // R3: entry sets the lock
  a_r3_lock_on_entry: assert property (@(posedge clk) disable iff (!por_n)
    sleep_enter |=> lock_q);
  // R4: retained copy is frozen while locked
  a_r4_held_frozen: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> $stable(held_q));
  // R6: clear write without entry releases
  a_r6_release: assert property (@(posedge clk) disable iff (!por_n)
    release_ev |=> !lock_q);
  // R6: lock only rises on an entry event
  a_r6_rise_only_entry: assert property (@(posedge clk) disable iff (!por_n)
    $rose(lock_q) |-> $past(sleep_enter));
endmodule

// File: rtl/hold_flags.sv
module hold_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] ies,
  input  logic [N-1:0] ie,
  input  logic         locked,
  input  logic         sleep_enter,
  input  logic         flag_wr,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] flags_q,
  output logic         wake_q
);
  function automatic logic [N-1:0] edge_hits(input logic [N-1:0] cur,
                                             input logic [N-1:0] prev,
                                             input logic [N-1:0] sel);
    return (~sel & cur & ~prev) | (sel & ~cur & prev);
  endfunction

  function automatic logic [N-1:0] flag_write(input logic [N-1:0] old,
                                              input logic [N-1:0] data,
                                              input logic lk);
    return lk ? (old | data) : data;
  endfunction

  logic [N-1:0] prev_q;
  logic [N-1:0] hits;
  logic [N-1:0] flags_d;
  logic         asleep_q;
  logic         wake_ev;

  assign hits    = edge_hits(pad_in, prev_q, ies);
  assign flags_d = (flag_wr ? flag_write(flags_q, wr_data, locked) : flags_q) | hits;
  assign wake_ev = asleep_q && |(hits & ie);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prev_q   <= '0;
      flags_q  <= '0;
      asleep_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      prev_q  <= pad_in;
      flags_q <= flags_d;
      wake_q  <= wake_ev;
      if (wake_ev)          asleep_q <= 1'b0;
      else if (sleep_enter) asleep_q <= 1'b1;
    end
  end

  // R8: no flag bit falls while locked
  a_r8_no_clear_locked: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  // R9: wake only out of sleep
  a_r9_wake_from_sleep: assert property (@(posedge clk) disable iff (!por_n)
    wake_q |-> $past(asleep_q));
  // R9: wake request lasts one cycle
  a_r9_wake_pulse: assert property (@(posedge clk) disable iff (!por_n)
    wake_q |=> !wake_q);
endmodule

// File: rtl/pad_hold_lock.sv
module pad_hold_lock
  import hold_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         rst_n,
  input  logic         sleep_enter,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_do,
  output logic [N-1:0] pad_pull_en,
  output logic [N-1:0] pad_pull_up,
  output logic [N-1:0] pad_drive,
  output logic         lock_active,
  output logic [N-1:0] irq_flags,
  output logic         wake_req
);
  logic [CFG_REGS-1:0][N-1:0]   cfg_q;
  logic [PAD_FIELDS-1:0][N-1:0] live;
  logic [PAD_FIELDS-1:0][N-1:0] pads;
  logic lock_clr;
  logic flag_wr;

  assign lock_clr = wr_en && (wr_addr == A_LOCK) && !wr_data[0];
  assign flag_wr  = wr_en && (wr_addr == A_FLAG);

  hold_cfg_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_q(cfg_q)
  );

  assign live[F_OE]  = cfg_q[A_DIR];
  assign live[F_DO]  = cfg_q[A_OUT];
  assign live[F_PEN] = cfg_q[A_PEN] & ~cfg_q[A_DIR];
  assign live[F_PUP] = cfg_q[A_OUT];
  assign live[F_DRV] = cfg_q[A_DS];

  hold_latch #(.N(N)) u_latch (
    .clk(clk), .por_n(por_n), .sleep_enter(sleep_enter), .lock_clr(lock_clr),
    .live(live), .pads(pads), .lock_q(lock_active)
  );

  hold_flags #(.N(N)) u_flags (
    .clk(clk), .por_n(por_n), .pad_in(pad_in), .ies(cfg_q[A_IES]),
    .ie(cfg_q[A_IE]), .locked(lock_active), .sleep_enter(sleep_enter),
    .flag_wr(flag_wr), .wr_data(wr_data), .flags_q(irq_flags), .wake_q(wake_req)
  );

  assign pad_oe      = pads[F_OE];
  assign pad_do      = pads[F_DO];
  assign pad_pull_en = pads[F_PEN];
  assign pad_pull_up = pads[F_PUP];
  assign pad_drive   = pads[F_DRV];

  // R5: pads do not move across a wake-up reset while locked
  a_r5_pads_survive_reset: assert property (@(posedge clk) disable iff (!por_n)
    (lock_active && $past(lock_active)) |-> ($stable(pad_oe) && $stable(pad_do)
      && $stable(pad_pull_en) && $stable(pad_drive)));
endmodule

// File: tb/tb_pad_hold_lock.sv
module tb_pad_hold_lock;
  localparam int N = 8;
  localparam time TCLK = 10;

  logic clk = 0, por_n = 0, rst_n = 0, sleep_enter = 0, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [N-1:0] wr_data = 0, pad_in = 0;
  logic [N-1:0] pad_oe, pad_do, pad_pull_en, pad_pull_up, pad_drive, irq_flags;
  logic lock_active, wake_req;
  int checks = 0, fails = 0;

  always #(TCLK/2) clk = ~clk;

  pad_hold_lock #(.N(N)) dut (.*);

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pads_are(string req, logic [N-1:0] oe, logic [N-1:0] dout,
                          logic [N-1:0] pe, logic [N-1:0] drv);
    chk(req, pad_oe, oe); chk(req, pad_do, dout);
    chk(req, pad_pull_en, pe); chk(req, pad_pull_up, dout);
    chk(req, pad_drive, drv);
  endtask

  task automatic t_reset;
    chk("R1 lock", N'(lock_active), 0); chk("R1 flags", irq_flags, 0);
    chk("R1 wake", N'(wake_req), 0);
    pads_are("R1 pads", 0, 0, 0, 0);
  endtask

  task automatic t_live;
    wr(0, 8'hF0); wr(1, 8'hAA); wr(2, 8'h3F); wr(3, 8'h3C);
    pads_are("R2 live", 8'hF0, 8'hAA, 8'h0F, 8'h3C);
  endtask

  task automatic t_enter;
    @(negedge clk); sleep_enter = 1;
    @(negedge clk); sleep_enter = 0;
    chk("R3 lock set", N'(lock_active), 1);
    pads_are("R3 captured", 8'hF0, 8'hAA, 8'h0F, 8'h3C);
  endtask

  task automatic t_locked_writes;
    wr(0, 8'h00); wr(1, 8'h55); wr(3, 8'hFF);
    pads_are("R4 frozen", 8'hF0, 8'hAA, 8'h0F, 8'h3C);
  endtask

  task automatic t_wake;
    wr(5, 8'h01);
    @(negedge clk); pad_in = 8'h02;
    @(negedge clk);
    chk("R9 flag no-ie", irq_flags, 8'h02); chk("R9 no wake", N'(wake_req), 0);
    pad_in = 8'h03;
    @(negedge clk);
    chk("R9 flag ie", irq_flags, 8'h03); chk("R9 wake", N'(wake_req), 1);
    @(negedge clk);
    chk("R9 pulse", N'(wake_req), 0);
    pad_in = 8'h02;
    @(negedge clk); pad_in = 8'h03;
    @(negedge clk);
    chk("R9 awake no wake", N'(wake_req), 0);
  endtask

  task automatic t_wake_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R5 lock kept", N'(lock_active), 1);
    chk("R5 flags kept", irq_flags, 8'h03);
    pads_are("R5 pads kept", 8'hF0, 8'hAA, 8'h0F, 8'h3C);
  endtask

  task automatic t_flag_locked;
    wr(6, 8'h00); chk("R8 no clear", irq_flags, 8'h03);
    wr(6, 8'h04); chk("R8 set ok", irq_flags, 8'h07);
  endtask

  task automatic t_release;
    wr(7, 8'h01); chk("R6 write1 ignored", N'(lock_active), 1);
    pads_are("R6 still held", 8'hF0, 8'hAA, 8'h0F, 8'h3C);
    wr(0, 8'h81); wr(1, 8'h03);
    wr(7, 8'h00); chk("R6 cleared", N'(lock_active), 0);
    pads_are("R6 live", 8'h81, 8'h03, 8'h00, 8'h00);
  endtask

  task automatic t_flag_unlocked;
    wr(6, 8'h01); chk("R8 replace", irq_flags, 8'h01);
  endtask

  task automatic t_edges;
    wr(4, 8'h10);
    @(negedge clk); pad_in = 8'h13;
    @(negedge clk); chk("R7 rise ignored", irq_flags, 8'h01);
    pad_in = 8'h03;
    @(negedge clk); chk("R7 fall sets", irq_flags, 8'h11);
    pad_in = 8'h23;
    @(negedge clk); chk("R7 rise sets", irq_flags, 8'h31);
    pad_in = 8'h03;
    @(negedge clk); chk("R7 fall ignored", irq_flags, 8'h31);
  endtask

  task automatic t_collide;
    @(negedge clk); sleep_enter = 1; wr_en = 1; wr_addr = 7; wr_data = 0;
    @(negedge clk); sleep_enter = 0; wr_en = 0;
    chk("R6 entry wins", N'(lock_active), 1);
    wr(7, 8'h00); chk("R6 clear after", N'(lock_active), 0);
  endtask

  initial begin
    #(TCLK*400);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    por_n = 1; rst_n = 1;
    @(negedge clk);
    t_live; t_enter; t_locked_writes; t_wake; t_wake_reset;
    t_flag_locked; t_release; t_flag_unlocked; t_edges; t_collide;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule